// File: doc/BRIEF.md
# Next-PC Branch Prediction Unit

This unit sits in the fetch frontend of a 64-bit RISC-V core that fetches 32 bits per cycle. Each cycle it takes the current fetch PC and pre-decoded control-flow hints for that fetch. The hints are the control-flow kind, the sign-extended immediate, whether the instruction is a call or a return, and whether it is a compressed (16-bit) instruction. From these it produces the predicted next fetch address combinationally, together with a flag that marks a predicted redirect.

Prediction draws on four sources:
- a table of 2-bit saturating counters for conditional branches;
- a fixed sign-of-immediate rule, used when the counter table has nothing valid;
- a target buffer for register-indirect jumps;
- a return address stack for returns.

The execute stage reports resolved control flow back into the unit. Those reports train the counters and the target buffer. When the report flags a misprediction, it is turned into a redirect to the corrected PC.

Top module: `npc_predictor`

## Requirements
- R1: When no prediction applies, `npc_o` is the fetch PC with bits [1:0] cleared plus 4, and `npc_taken_o` is 0.
- R2: For kind 2 (PC-relative jump), `npc_o` is `fetch_pc_i + cf_imm_i` and `npc_taken_o` is 1.
- R3: For kind 1 (conditional branch) whose counter entry is invalid, the branch is predicted taken when `cf_imm_i[63]` is 1, with target `fetch_pc_i + cf_imm_i`. When `cf_imm_i[63]` is 0 it is not predicted (R1).
- R4: The counter entry is selected by PC bits [4:2]. A branch resolution (`res_valid_i` with `res_branch_i`=1) marks the entry valid.
  - On the first write to an entry, the counter is set to 2 for taken and 1 for not taken.
  - After that, the counter increments on taken and decrements on not taken, saturating at 3 and 0.
  - A valid entry overrides R3 and predicts taken when its counter is 2 or 3.
- R5: For kind 3 with `cf_ret_i`=1 and `cf_call_i`=0, a non-empty return stack predicts its top entry (`npc_taken_o`=1). When `fetch_valid_i` is 1, the top entry is popped.
- R6: When `fetch_valid_i`=1, `cf_call_i`=1 and the kind is 2 or 3, the return address is pushed. It is `fetch_pc_i+2` when `cf_rvc_i`=1 and `fetch_pc_i+4` otherwise. Entries come back last-in first-out.
- R7: The return stack holds 4 entries. A fifth push overwrites the oldest entry. A return with an empty stack is not predicted (R1), including when the target buffer holds an entry.
- R8: For kind 3 that is not a return, a valid target buffer entry (index PC bits [4:2]) gives `npc_o` = stored target with `npc_taken_o`=1. An invalid entry gives R1.
- R9: A resolution with `res_branch_i`=0 writes `res_target_i` into the target buffer entry at `res_pc_i` bits [4:2] and marks it valid.
- R10: In the same cycle, `redirect_o` equals `res_valid_i & res_mispredict_i`. While `redirect_o` is 1, `redirect_pc_o` equals `res_target_i`.
- R11: Reset invalidates every counter and target buffer entry and empties the return stack.
- R12: With `fetch_valid_i`=0 the prediction is still produced, but the return stack is not changed.

Kind encoding on `cf_kind_i`: 0 none, 1 conditional branch, 2 PC-relative jump, 3 register-indirect jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | Current fetch is real; gates return stack updates |
| fetch_pc_i | input | 64 | Current fetch PC |
| cf_kind_i | input | 2 | Pre-decoded control-flow kind |
| cf_imm_i | input | 64 | Sign-extended immediate |
| cf_call_i | input | 1 | Instruction is a call |
| cf_ret_i | input | 1 | Instruction is a return |
| cf_rvc_i | input | 1 | Instruction is compressed |
| res_valid_i | input | 1 | Execute reports a resolution |
| res_pc_i | input | 64 | PC of the resolved instruction |
| res_branch_i | input | 1 | Resolution is a conditional branch (else indirect jump) |
| res_taken_i | input | 1 | Resolved branch outcome |
| res_target_i | input | 64 | Resolved/corrected target |
| res_mispredict_i | input | 1 | Resolution was mispredicted |
| npc_o | output | 64 | Predicted next fetch PC |
| npc_taken_o | output | 1 | Prediction redirects fetch |
| redirect_o | output | 1 | Misprediction redirect request |
| redirect_pc_o | output | 64 | Corrected PC for the redirect |

## Verification
The hardest states to reach from the ports are the counter saturation edges. Stimulus gets there with resolution sequences that would end in a different prediction if a counter wrapped instead of saturating. For example, two not-taken resolutions from 1 followed by two taken ones must end in a taken prediction.

Return stack overflow is reached with five back-to-back calls. Returns then pop four entries in reverse order and show the stack empty, without the fifth-oldest address. Reset clearing is checked by repeating, after a second reset, fetches that trained entries would otherwise have predicted.

// File: rtl/npc_predictor.sv
module npc_predictor #(
  parameter int XLEN        = 64,
  parameter int BHT_ENTRIES = 8,
  parameter int BTB_ENTRIES = 8,
  parameter int RAS_DEPTH   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_valid_i,
  input  logic [XLEN-1:0] fetch_pc_i,
  input  logic [1:0]      cf_kind_i,
  input  logic [XLEN-1:0] cf_imm_i,
  input  logic            cf_call_i,
  input  logic            cf_ret_i,
  input  logic            cf_rvc_i,
  input  logic            res_valid_i,
  input  logic [XLEN-1:0] res_pc_i,
  input  logic            res_branch_i,
  input  logic            res_taken_i,
  input  logic [XLEN-1:0] res_target_i,
  input  logic            res_mispredict_i,
  output logic [XLEN-1:0] npc_o,
  output logic            npc_taken_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o
);
  localparam int BHT_IW = $clog2(BHT_ENTRIES);
  localparam int BTB_IW = $clog2(BTB_ENTRIES);
  localparam int RAS_PW = $clog2(RAS_DEPTH);
  localparam logic [RAS_PW:0] RAS_FULL = (RAS_PW+1)'(RAS_DEPTH);
  localparam logic [1:0] K_BR = 2'd1, K_JAL = 2'd2, K_JALR = 2'd3;

  logic [1:0]             bht_ctr [BHT_ENTRIES];
  logic [BHT_ENTRIES-1:0] bht_vld;
  logic [XLEN-1:0]        btb_tgt [BTB_ENTRIES];
  logic [BTB_ENTRIES-1:0] btb_vld;
  logic [XLEN-1:0]        ras_mem [RAS_DEPTH];
  logic [RAS_PW-1:0]      ras_ptr;
  logic [RAS_PW:0]        ras_cnt;

  wire [BHT_IW-1:0] f_bidx = fetch_pc_i[BHT_IW+1:2];
  wire [BTB_IW-1:0] f_tidx = fetch_pc_i[BTB_IW+1:2];
  wire [BHT_IW-1:0] r_bidx = res_pc_i[BHT_IW+1:2];
  wire [BTB_IW-1:0] r_tidx = res_pc_i[BTB_IW+1:2];

  wire [RAS_PW-1:0] top_idx   = ras_ptr - RAS_PW'(1);
  wire              ras_empty = (ras_cnt == '0);
  wire [XLEN-1:0]   rel_tgt   = fetch_pc_i + cf_imm_i;
  wire [XLEN-1:0]   seq_pc    = {fetch_pc_i[XLEN-1:2], 2'b00} + XLEN'(4);
  wire [XLEN-1:0]   ret_addr  = fetch_pc_i + (cf_rvc_i ? XLEN'(2) : XLEN'(4));
  wire              br_taken  = bht_vld[f_bidx] ? bht_ctr[f_bidx][1] : cf_imm_i[XLEN-1];
  wire              is_ret    = (cf_kind_i == K_JALR) && cf_ret_i && !cf_call_i;

  wire push = fetch_valid_i && cf_call_i && cf_kind_i[1];
  wire pop  = fetch_valid_i && is_ret && !ras_empty;

  always_comb begin
    npc_taken_o = 1'b0;
    npc_o       = seq_pc;
    unique case (cf_kind_i)
      K_BR:  if (br_taken) begin npc_taken_o = 1'b1; npc_o = rel_tgt; end
      K_JAL: begin npc_taken_o = 1'b1; npc_o = rel_tgt; end
      K_JALR: begin
        if (is_ret) begin
          if (!ras_empty) begin npc_taken_o = 1'b1; npc_o = ras_mem[top_idx]; end
        end else if (btb_vld[f_tidx]) begin
          npc_taken_o = 1'b1;
          npc_o       = btb_tgt[f_tidx];
        end
      end
      default: ;
    endcase
  end

  assign redirect_o    = res_valid_i && res_mispredict_i;
  assign redirect_pc_o = res_target_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      bht_vld <= '0;
      btb_vld <= '0;
      for (int i = 0; i < BHT_ENTRIES; i++) bht_ctr[i] <= 2'd0;
      for (int i = 0; i < BTB_ENTRIES; i++) btb_tgt[i] <= '0;
    end else if (res_valid_i) begin
      if (res_branch_i) begin
        bht_vld[r_bidx] <= 1'b1;
        if (!bht_vld[r_bidx])
          bht_ctr[r_bidx] <= res_taken_i ? 2'd2 : 2'd1;
        else if (res_taken_i && bht_ctr[r_bidx] != 2'd3)
          bht_ctr[r_bidx] <= bht_ctr[r_bidx] + 2'd1;
        else if (!res_taken_i && bht_ctr[r_bidx] != 2'd0)
          bht_ctr[r_bidx] <= bht_ctr[r_bidx] - 2'd1;
      end else begin
        btb_vld[r_tidx] <= 1'b1;
        btb_tgt[r_tidx] <= res_target_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ras_ptr <= '0;
      ras_cnt <= '0;
      for (int i = 0; i < RAS_DEPTH; i++) ras_mem[i] <= '0;
    end else if (push) begin
      ras_mem[ras_ptr] <= ret_addr;
      ras_ptr          <= ras_ptr + RAS_PW'(1);
      if (ras_cnt != RAS_FULL) ras_cnt <= ras_cnt + (RAS_PW+1)'(1);
    end else if (pop) begin
      ras_ptr <= top_idx;
      ras_cnt <= ras_cnt - (RAS_PW+1)'(1);
    end
  end
endmodule

// File: rtl/npc_predictor_chk.sv
module npc_predictor_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fetch_valid_i,
  input logic [XLEN-1:0] fetch_pc_i,
  input logic [1:0]      cf_kind_i,
  input logic [XLEN-1:0] cf_imm_i,
  input logic            cf_call_i,
  input logic            cf_ret_i,
  input logic            cf_rvc_i,
  input logic            res_valid_i,
  input logic [XLEN-1:0] res_pc_i,
  input logic            res_branch_i,
  input logic            res_taken_i,
  input logic [XLEN-1:0] res_target_i,
  input logic            res_mispredict_i,
  input logic [XLEN-1:0] npc_o,
  input logic            npc_taken_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o
);
  // R1
  seq_fallthrough_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !npc_taken_o |-> npc_o == ({fetch_pc_i[XLEN-1:2], 2'b00} + XLEN'(4)));

  // R2
  jal_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cf_kind_i == 2'd2 |-> (npc_taken_o && npc_o == fetch_pc_i + cf_imm_i));

  // R3
  branch_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_kind_i == 2'd1 && npc_taken_o) |-> npc_o == fetch_pc_i + cf_imm_i);

  // R5
  call_then_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(fetch_valid_i && cf_call_i && cf_kind_i[1]) &&
     cf_kind_i == 2'd3 && cf_ret_i && !cf_call_i)
    |-> (npc_taken_o && npc_o == $past(fetch_pc_i) + ($past(cf_rvc_i) ? XLEN'(2) : XLEN'(4))));

  // R10
  redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_mispredict_i) |-> (redirect_o && redirect_pc_o == res_target_i));

  // R10
  no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_i && res_mispredict_i) |-> !redirect_o);
endmodule

bind npc_predictor npc_predictor_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_npc_predictor.sv
module sim_npc_predictor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [63:0] fetch_pc_i = '0;
  logic [1:0]  cf_kind_i = '0;
  logic [63:0] cf_imm_i = '0;
  logic        cf_call_i = 1'b0, cf_ret_i = 1'b0, cf_rvc_i = 1'b0;
  logic        res_valid_i = 1'b0;
  logic [63:0] res_pc_i = '0;
  logic        res_branch_i = 1'b0, res_taken_i = 1'b0, res_mispredict_i = 1'b0;
  logic [63:0] res_target_i = '0;
  logic [63:0] npc_o;
  logic        npc_taken_o;
  logic        redirect_o;
  logic [63:0] redirect_pc_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  npc_predictor u0 (.*);

  always #5 clk_i = ~clk_i;

  typedef struct packed {
    logic [1:0]  kind;
    logic        call, ret, rvc;
    logic [63:0] pc, imm, exp_pc;
    logic        exp_tk;
  } vec_t;

  localparam logic [63:0] NEG16 = 64'hFFFF_FFFF_FFFF_FFF0;
  localparam logic [63:0] NEG8  = 64'hFFFF_FFFF_FFFF_FFF8;

  localparam vec_t VECS [10] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 64'h1000, 64'h0,  64'h1004, 1'b0}, // R1
    '{2'd0, 1'b0, 1'b0, 1'b0, 64'h1002, 64'h0,  64'h1004, 1'b0}, // R1 aligned
    '{2'd2, 1'b0, 1'b0, 1'b0, 64'h1000, 64'h40, 64'h1040, 1'b1}, // R2
    '{2'd2, 1'b0, 1'b0, 1'b0, 64'h2000, NEG16,  64'h1FF0, 1'b1}, // R2 backward
    '{2'd1, 1'b0, 1'b0, 1'b0, 64'h3000, NEG8,   64'h2FF8, 1'b1}, // R3 backward taken
    '{2'd1, 1'b0, 1'b0, 1'b0, 64'h3000, 64'h20, 64'h3004, 1'b0}, // R3 forward not taken
    '{2'd1, 1'b0, 1'b0, 1'b0, 64'h3006, 64'h10, 64'h3008, 1'b0}, // R3 forward, R1 align
    '{2'd3, 1'b0, 1'b0, 1'b0, 64'h4000, 64'h0,  64'h4004, 1'b0}, // R8 empty buffer
    '{2'd3, 1'b0, 1'b1, 1'b0, 64'h5006, 64'h0,  64'h5008, 1'b0}, // R7 empty stack
    '{2'd2, 1'b1, 1'b0, 1'b0, 64'h1000, 64'h40, 64'h1040, 1'b1}  // R2 call, R12 no push
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pred(input string req, input logic [63:0] exp_pc, input logic exp_tk);
    #1;
    chk(req, npc_o, exp_pc);
    chk(req, 64'(npc_taken_o), 64'(exp_tk));
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic fetch(input logic [1:0] k, input logic [63:0] pc, input logic [63:0] imm,
                       input logic call, input logic ret, input logic rvc, input logic vld);
    cf_kind_i = k; fetch_pc_i = pc; cf_imm_i = imm;
    cf_call_i = call; cf_ret_i = ret; cf_rvc_i = rvc; fetch_valid_i = vld;
  endtask

  task automatic resolve(input logic [63:0] pc, input logic br, input logic tk, input logic [63:0] tgt);
    res_valid_i = 1'b1; res_pc_i = pc; res_branch_i = br; res_taken_i = tk; res_target_i = tgt;
    step();
    res_valid_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11 reset state
    fetch(2'd0, 64'h0, 64'h0, 0, 0, 0, 0);
    pred("R11", 64'h4, 1'b0);
    chk("R11", 64'(redirect_o), 64'h0);

    for (int i = 0; i < 10; i++) begin
      fetch(VECS[i].kind, VECS[i].pc, VECS[i].imm, VECS[i].call, VECS[i].ret, VECS[i].rvc, 1'b0);
      pred($sformatf("vector %0d", i), VECS[i].exp_pc, VECS[i].exp_tk);
      step();
    end

    // R4 counter training at index 0
    fetch(2'd0, 64'h0, 64'h0, 0, 0, 0, 0);
    resolve(64'h3000, 1, 1, 64'h3020);
    fetch(2'd1, 64'h3000, 64'h20, 0, 0, 0, 0);
    pred("R4 first taken", 64'h3020, 1'b1);
    resolve(64'h3000, 1, 0, 64'h3004);
    pred("R4 decrement", 64'h3004, 1'b0);
    cf_imm_i = NEG8;
    pred("R4 overrides static", 64'h3004, 1'b0);
    cf_imm_i = 64'h20;
    resolve(64'h3000, 1, 0, 64'h3004);
    resolve(64'h3000, 1, 0, 64'h3004);
    resolve(64'h3000, 1, 1, 64'h3020);
    resolve(64'h3000, 1, 1, 64'h3020);
    pred("R4 saturate low", 64'h3020, 1'b1);
    repeat (4) resolve(64'h3000, 1, 1, 64'h3020);
    resolve(64'h3000, 1, 0, 64'h3004);
    pred("R4 saturate high", 64'h3020, 1'b1);
    resolve(64'h3000, 1, 0, 64'h3004);
    pred("R4 weak not taken", 64'h3004, 1'b0);
    resolve(64'h3004, 1, 0, 64'h3008);
    fetch(2'd1, 64'h3004, NEG8, 0, 0, 0, 0);
    pred("R4 first not taken", 64'h3008, 1'b0);

    // R9 / R8 target buffer
    resolve(64'h4000, 0, 1, 64'hABC0);
    fetch(2'd3, 64'h4000, 64'h0, 0, 0, 0, 0);
    pred("R8 R9 buffer hit", 64'hABC0, 1'b1);
    fetch(2'd3, 64'h4000, 64'h0, 0, 1, 0, 0);
    pred("R7 empty return ignores buffer", 64'h4004, 1'b0);

    // R6 / R5 return stack
    fetch(2'd2, 64'h6000, 64'h100, 1, 0, 0, 1);
    step();
    fetch(2'd3, 64'h6100, 64'h0, 1, 0, 1, 1);
    step();
    fetch(2'd3, 64'h7000, 64'h0, 0, 1, 0, 1);
    pred("R5 R6 compressed call", 64'h6102, 1'b1);
    step();
    pred("R5 R6 full call", 64'h6004, 1'b1);
    step();
    pred("R7 empty after pops", 64'h7004, 1'b0);
    step();

    // R12 invalid fetch does not push
    fetch(2'd2, 64'h6200, 64'h40, 1, 0, 0, 0);
    step();
    fetch(2'd3, 64'h7000, 64'h0, 0, 1, 0, 1);
    pred("R12 no push", 64'h7004, 1'b0);

    // R7 overflow
    for (int i = 1; i <= 5; i++) begin
      fetch(2'd2, 64'(i * 256), 64'h40, 1, 0, 0, 1);
      step();
    end
    fetch(2'd3, 64'h7000, 64'h0, 0, 1, 0, 1);
    for (int i = 5; i >= 2; i--) begin
      pred("R7 overflow order", 64'(i * 256 + 4), 1'b1);
      step();
    end
    pred("R7 oldest overwritten", 64'h7004, 1'b0);
    fetch(2'd0, 64'h0, 64'h0, 0, 0, 0, 0);

    // R10 redirect
    res_valid_i = 1'b1; res_pc_i = 64'h9000; res_branch_i = 1'b1; res_taken_i = 1'b1;
    res_target_i = 64'h8880; res_mispredict_i = 1'b1;
    #1;
    chk("R10 redirect", 64'(redirect_o), 64'h1);
    chk("R10 redirect pc", redirect_pc_o, 64'h8880);
    step();
    res_mispredict_i = 1'b0;
    #1;
    chk("R10 no redirect", 64'(redirect_o), 64'h0);
    step();
    res_valid_i = 1'b0;

    // R11 second reset clears trained state
    rst_ni = 1'b0;
    step();
    step();
    rst_ni = 1'b1;
    fetch(2'd1, 64'h3000, 64'h20, 0, 0, 0, 0);
    pred("R11 counters cleared", 64'h3004, 1'b0);
    fetch(2'd3, 64'h4000, 64'h0, 0, 0, 0, 0);
    pred("R11 buffer cleared", 64'h4004, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule